// File: doc/BRIEF.md
# Single-Precision Register Format Converter

This block moves single-precision values between their 32-bit memory image and a 64-bit register image. The register image uses an 11-bit exponent, so a single value is held in the same field layout as a double. It does three jobs. On a load it expands a 32-bit image into the register form. On a store it compresses a register word back to 32 bits. It also packs a 64-bit integer into the 32-bit integer ("longword") layout that the register file keeps, and reports when that integer does not fit in 32 signed bits.

The block only moves bits and remaps exponents. It does no rounding and no arithmetic. Each request is presented with an operation code and a data word under a valid strobe. The result appears one clock later under its own valid strobe, together with an integer-overflow flag and an inexact flag.

Top module: `sfmt_convert`

## Requirements
- R1: Expand (op code 0) takes in_data[31:0]. It places bit 31 at output bit 63 and the 23 fraction bits [22:0] at output bits 51:29. Output bits 28:0 are zero.
- R2: In expand, memory exponent bit 30 becomes register exponent bit 10 (output bit 62), and memory exponent bits 29:23 become register exponent bits 6:0 (output bits 58:52). When bit 30 is 1 and bits 29:23 are not all ones, register exponent bits 9:7 are zero.
- R3: In expand, when bit 30 is 1 and bits 29:23 are all ones, the 11-bit register exponent is 0x7FF.
- R4: In expand, when bit 30 is 0 and bits 29:23 are nonzero, register exponent bits 9:7 are ones. When bit 30 and bits 29:23 are all zero, the register exponent is zero.
- R5: Compress (op code 1) sets output bits 31:30 from in_data[63:62] and output bits 29:0 from in_data[58:29]. Output bits 63:32 are zero, and in_data bits 61:59 and 28:0 have no effect.
- R6: Pack (op code 2) sets output bits 63:62 from in_data[31:30] and output bits 58:29 from in_data[29:0]. Every other output bit is zero.
- R7: Pack sets out_iov and out_ine together when in_data differs from the sign extension of in_data[31:0]. Both flags are clear when the value fits, including -2^31 and 2^31-1.
- R8: Expand, compress and op code 3 always return both flags clear. Op code 3 returns an all-zero word.
- R9: A request accepted while in_valid is high appears on the outputs with out_valid high exactly one cycle later. When in_valid is low, out_valid goes low on the next cycle and out_data keeps its value.
- R10: Synchronous active-high reset clears out_valid, out_data and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | 0 expand, 1 compress, 2 pack, 3 unused |
| in_data | input | 64 | Operand; expand reads bits 31:0 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 64 | Converted word |
| out_iov | output | 1 | Integer overflow from pack |
| out_ine | output | 1 | Inexact, raised together with out_iov |

## Verification
Expand is tried with one image from each exponent class: all-zero exponent (zero and denormal), top bit clear with a nonzero low part (normal values such as 1.0), top bit set with a low part that is not all ones, and the all-ones exponent (infinity and NaN). These classes separate the three remapping rules and show whether the sign and fraction land in the right place. Compress is fed words with junk in the dropped bit ranges, to show that those bits are ignored. Pack is tried on values just inside and just outside the signed 32-bit range, and on large positive and negative values, to test the overflow boundary from both sides. The requests run back to back and with idle gaps, which checks the strobe timing and that the result holds between requests.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;

    localparam int MEM_W     = 32;
    localparam int REG_W     = 64;
    localparam int MEXP_W    = 8;
    localparam int REXP_W    = 11;
    localparam int FRAC_W    = 23;
    localparam int RFRAC_W   = 52;
    localparam int PAD_W     = RFRAC_W - FRAC_W;          // 29 zero bits below fraction
    localparam int LOWEXP_W  = MEXP_W - 1;                // 7
    localparam int MID_W     = REXP_W - MEXP_W;           // 3 filled bits
    localparam int LW_HI_W   = 2;
    localparam int LW_LO_W   = MEM_W - LW_HI_W;           // 30
    localparam int LW_GAP_W  = REG_W - LW_HI_W - LW_LO_W - PAD_W; // 3

    typedef enum logic [1:0] {
        OP_EXPAND   = 2'd0,
        OP_COMPRESS = 2'd1,
        OP_PACK     = 2'd2,
        OP_NONE     = 2'd3
    } sfmt_op_e;

    typedef struct packed {
        logic [REG_W-1:0] data;
        logic             iov;
        logic             ine;
    } sfmt_res_t;

    // Widen an 8-bit memory exponent to the 11-bit register exponent.
    function automatic logic [REXP_W-1:0] widen_exp(input logic [MEXP_W-1:0] e);
        logic                top;
        logic [LOWEXP_W-1:0] low;
        logic [MID_W-1:0]    mid;
        top = e[MEXP_W-1];
        low = e[LOWEXP_W-1:0];
        if (top && (&low))
            return {REXP_W{1'b1}};
        mid = (!top && (|low)) ? {MID_W{1'b1}} : {MID_W{1'b0}};
        return {top, mid, low};
    endfunction

endpackage

// File: rtl/sfmt_expand.sv
module sfmt_expand
    import sfmt_pkg::*;
(
    input  logic [MEM_W-1:0] mem_word,
    output logic [REG_W-1:0] reg_word
);
    logic              sgn;
    logic [MEXP_W-1:0] mexp;
    logic [FRAC_W-1:0] frac;
    logic [REXP_W-1:0] rexp;

    always_comb begin
        sgn  = mem_word[MEM_W-1];
        mexp = mem_word[MEM_W-2 -: MEXP_W];
        frac = mem_word[FRAC_W-1:0];
        rexp = widen_exp(mexp);
        reg_word = {sgn, rexp, frac, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/sfmt_compress.sv
module sfmt_compress
    import sfmt_pkg::*;
(
    input  logic [REG_W-1:0] reg_word,
    output logic [REG_W-1:0] mem_word
);
    logic [MEM_W-1:0] slice;

    // Top two bits straight across, remaining bits from the fraction window.
    for (genvar g = 0; g < MEM_W; g++) begin : g_map
        if (g >= LW_LO_W) begin : g_hi
            assign slice[g] = reg_word[g + REG_W - MEM_W];
        end else begin : g_lo
            assign slice[g] = reg_word[g + PAD_W];
        end
    end

    assign mem_word = {{(REG_W-MEM_W){1'b0}}, slice};
endmodule

// File: rtl/sfmt_pack.sv
module sfmt_pack
    import sfmt_pkg::*;
(
    input  logic [REG_W-1:0] int_word,
    output logic [REG_W-1:0] reg_word,
    output logic             ovf
);
    logic [MEM_W-1:0] low;

    always_comb begin
        low      = int_word[MEM_W-1:0];
        ovf      = (int_word != {{(REG_W-MEM_W){low[MEM_W-1]}}, low});
        reg_word = {low[MEM_W-1 -: LW_HI_W], {LW_GAP_W{1'b0}},
                    low[LW_LO_W-1:0], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/sfmt_convert.sv
module sfmt_convert
    import sfmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       in_op,
    input  logic [63:0]      in_data,
    output logic             out_valid,
    output logic [63:0]      out_data,
    output logic             out_iov,
    output logic             out_ine
);
    logic [REG_W-1:0] exp_w, cmp_w, pck_w;
    logic             pck_ovf;
    sfmt_res_t        nxt, cur;
    logic             vld_q;

    sfmt_expand   u_expand   (.mem_word(in_data[MEM_W-1:0]), .reg_word(exp_w));
    sfmt_compress u_compress (.reg_word(in_data), .mem_word(cmp_w));
    sfmt_pack     u_pack     (.int_word(in_data), .reg_word(pck_w), .ovf(pck_ovf));

    always_comb begin
        nxt = '0;
        unique case (sfmt_op_e'(in_op))
            OP_EXPAND:   nxt.data = exp_w;
            OP_COMPRESS: nxt.data = cmp_w;
            OP_PACK: begin
                nxt.data = pck_w;
                nxt.iov  = pck_ovf;
                nxt.ine  = pck_ovf;
            end
            default:     nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid)
                cur <= nxt;
        end
    end

    assign out_valid = vld_q;
    assign out_data  = cur.data;
    assign out_iov   = cur.iov;
    assign out_ine   = cur.ine;
endmodule

// File: rtl/sfmt_convert_chk.sv
module sfmt_convert_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  in_op,
    input logic        out_valid,
    input logic [63:0] out_data,
    input logic        out_iov,
    input logic        out_ine
);
    a_r9_valid_next: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r9_idle_next: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
    a_r1_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd0) |=> out_data[28:0] == 29'd0);
    a_r6_pack_gaps: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd2) |=> (out_data[61:59] == 3'd0 && out_data[28:0] == 29'd0));
    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 2'd1) |=> out_data[63:32] == 32'd0);
    a_r8_no_flags: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op != 2'd2) |=> (!out_iov && !out_ine));
    a_r7_flags_pair: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_iov == out_ine);
endmodule

bind sfmt_convert sfmt_convert_chk i_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .out_valid(out_valid), .out_data(out_data),
    .out_iov(out_iov), .out_ine(out_ine)
);

// File: tb/test_sfmt_convert.sv
module test_sfmt_convert;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  in_op;
    logic [63:0] in_data;
    logic        out_valid;
    logic [63:0] out_data;
    logic        out_iov, out_ine;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] data;
        logic        flag;
        string       req;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    sfmt_convert i_sfmt_convert (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
        .out_iov(out_iov), .out_ine(out_ine)
    );

    function automatic logic [10:0] ref_exp(input logic [7:0] e);
        if (e[7] && e[6:0] == 7'h7F) return 11'h7FF;
        if (e[7])                    return {1'b1, 3'b000, e[6:0]};
        if (e[6:0] != 7'd0)          return {1'b0, 3'b111, e[6:0]};
        return 11'h000;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic [63:0] d, input string req);
        exp_t e;
        logic signed [63:0] sx;
        e.flag = 1'b0;
        e.req  = req;
        case (op)
            2'd0: e.data = {d[31], ref_exp(d[30:23]), d[22:0], 29'd0};
            2'd1: e.data = {32'd0, d[63:62], d[58:29]};
            2'd2: begin
                sx = $signed(d[31:0]);
                e.data = {d[31:30], 3'd0, d[29:0], 29'd0};
                e.flag = (sx != $signed(d));
            end
            default: e.data = 64'd0;
        endcase
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_data  = d;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 64'hDEAD_BEEF_0BAD_F00D;
    endtask

    // Monitor: scoreboard pop and compare
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_valid) begin
                if (sb.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9: unexpected out_valid, actual 1 expected 0");
                end else begin
                    e = sb.pop_front();
                    check(e.req, out_data, e.data);
                    check({e.req, " iov"}, {63'd0, out_iov}, {63'd0, e.flag});
                    check({e.req, " ine"}, {63'd0, out_ine}, {63'd0, e.flag});
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        rst = 1'b1; in_valid = 1'b0; in_op = 2'd0; in_data = '0;
        repeat (3) @(posedge clk);
        #2;
        // R10 reset state
        check("R10 valid", {63'd0, out_valid}, 64'd0);
        check("R10 data", out_data, 64'd0);
        check("R10 flags", {62'd0, out_iov, out_ine}, 64'd0);
        @(negedge clk); rst = 1'b0;

        // Expand: every exponent class
        drive(2'd0, 64'h0000_0000_3F80_0000, "R4 normal 1.0");
        drive(2'd0, 64'h0000_0000_00800000, "R4 smallest exp");
        drive(2'd0, 64'h0000_0000_0000_0000, "R4 zero");
        drive(2'd0, 64'h0000_0000_8001_2345, "R4 denormal");
        drive(2'd0, 64'h0000_0000_C049_0FDB, "R2 top set low zero");
        drive(2'd0, 64'h0000_0000_7F00_0000, "R2 top set low 7E");
        drive(2'd0, 64'h0000_0000_7F80_0000, "R3 infinity");
        drive(2'd0, 64'hFFFF_FFFF_FFC0_0001, "R3 nan upper junk");
        drive(2'd0, 64'h0000_0000_807F_FFFF, "R1 sign and fraction");
        idle();
        // Compress with junk in dropped ranges
        drive(2'd1, 64'h3FF0_0000_0000_0000, "R5 clean");
        drive(2'd1, 64'h4E00_0000_1FFF_FFFF, "R5 junk dropped");
        drive(2'd1, 64'hC7FF_FFFF_E000_0000, "R5 all kept ones");
        // Pack boundaries
        drive(2'd2, 64'h0000_0000_7FFF_FFFF, "R7 max fits");
        drive(2'd2, 64'hFFFF_FFFF_8000_0000, "R7 min fits");
        drive(2'd2, 64'h0000_0000_8000_0000, "R7 just over");
        drive(2'd2, 64'hFFFF_FFFF_7FFF_FFFF, "R7 just under");
        drive(2'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R6 minus one");
        drive(2'd2, 64'h8000_0000_0000_0000, "R7 large negative");
        drive(2'd2, 64'h0000_0001_0000_0000, "R7 large positive");
        drive(2'd2, 64'h0000_0000_9234_5678, "R6 scatter");
        // Unused code
        drive(2'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R8 unused code");
        drive(2'd0, 64'h0000_0000_4049_0FDB, "R8 expand no flags");
        idle();
        // R9 hold during idle
        @(posedge clk); #2;
        held = out_data;
        @(posedge clk); #2;
        check("R9 idle valid", {63'd0, out_valid}, 64'd0);
        check("R9 hold data", out_data, held);
        drive(2'd1, 64'h4000_0000_2000_0000, "R9 after gap");
        idle();
        repeat (3) @(posedge clk);
        #2;
        check("R9 scoreboard empty", 64'(sb.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule